// File: doc/BRIEF.md
# Phase-Continuous Trapezoid FSK Transmitter

This block turns a serial bit stream into a two-tone frequency-shift-keyed waveform for a half-duplex field-bus modem. It runs directly on the 460.8 kHz master clock and produces one DAC sample code per clock. Logic 1 selects the low (mark) tone, near 1200 Hz. Logic 0 selects the high (space) tone, near 2200 Hz. The transmit bit is read on every clock and used at once: nothing is framed or buffered, so the caller presents each bit for as long as it should last (384 clocks at 1200 bit/s).

Both tones come from one phase accumulator. Its modulus is four times the least common multiple of the two clock dividers (385 and 210), which gives 9240. Mark advances the phase by 24 per clock and space by 44, so the periods are exactly 385 and 210 clocks (1196.9 Hz and 2194.3 Hz). A tone change alters only the increment, never the phase, so the waveform has no jump at a bit boundary. The accumulator value is folded into a triangle and clipped at half its swing, which gives a trapezoid with flat tops rather than a square wave.

An active-low request-to-send gates the transmitter. While it is high, the code rests at mid-scale, the valid flag is low and the phase is parked at the zero-crossing point. The first sample after it falls is therefore exactly mid-scale. A receiver-disable output is high for as long as samples are being sent.

Top module: `fsk_tone_shaper`

## Requirements
- R1: With tx_bit held at 1 while transmitting, the waveform period is exactly 385 clocks, measured between successive upward crossings of mid-scale (code 2048).
- R2: With tx_bit held at 0 while transmitting, the waveform period is exactly 210 clocks.
- R3: While transmitting, two consecutive samples never differ by more than 44 codes, including at every change of tx_bit.
- R4: The waveform is a trapezoid. Its peak is code 3203, its trough is code 893, and it holds the peak for several consecutive samples in each period.
- R5: While rts_n is sampled high, from the next clock on dac_code is 2048 and dac_valid is 0.
- R6: One clock after rts_n is first sampled low, dac_valid is 1 and dac_code is 2048. The code then rises by 24 per clock for tx_bit=1, or by 44 per clock for tx_bit=0.
- R7: rx_disable is 1 exactly on the clocks where dac_valid is 1, and 0 otherwise.
- R8: tx_bit is not buffered. The value present at a clock edge sets the size of the sample step taken at that same edge.
- R9: A synchronous active-high reset returns dac_code to 2048, with dac_valid and rx_disable at 0, even in the middle of a transmission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 460.8 kHz master clock, one sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| rts_n | input | 1 | Request to send, active low; high disconnects the transmitter |
| tx_bit | input | 1 | Data bit; 1 selects mark, 0 selects space |
| dac_code | output | CODE_W (12) | Unsigned sample code for the external DAC, mid-scale 2048 |
| dac_valid | output | 1 | High while the sample code carries the waveform |
| rx_disable | output | 1 | High while transmitting, so the receiver stays off |

## Verification
A short vector table feeds an irregular mix of ones and zeros from the start of a transmission. It shows that each step follows the bit present at that very edge, and that the ramp picks up from the current amplitude rather than from a reset phase. Long runs of a single tone measure the period between upward mid-scale crossings; only the exact divisor count passes, which separates 385 from 210 and from any off-by-one. The same runs record the peak, the trough and the plateau length, which would expose a square or an unclipped triangle. Bits alternating at the 384-clock bit time, followed by toggling rts_n and a mid-stream reset, cover phase continuity across switches and the idle behaviour.

// File: rtl/fsk_tone_shaper.sv
module fsk_tone_shaper #(
  parameter int MARK_DIV  = 385,
  parameter int SPACE_DIV = 210,
  parameter int CODE_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rts_n,
  input  logic              tx_bit,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_valid,
  output logic              rx_disable
);

  function automatic int gcd_f(input int a, input int b);
    int x, y, r;
    x = a;
    y = b;
    while (y != 0) begin
      r = x % y;
      x = y;
      y = r;
    end
    return x;
  endfunction

  localparam int LCM       = (MARK_DIV / gcd_f(MARK_DIV, SPACE_DIV)) * SPACE_DIV;
  localparam int MOD       = 4 * LCM;
  localparam int HALF      = 2 * LCM;
  localparam int QTR       = LCM;
  localparam int CLIP      = QTR / 2;
  localparam int INC_MARK  = MOD / MARK_DIV;
  localparam int INC_SPACE = MOD / SPACE_DIV;
  localparam int MAX_STEP  = (INC_MARK > INC_SPACE) ? INC_MARK : INC_SPACE;
  localparam int MID       = 1 << (CODE_W - 1);
  localparam int PW        = $clog2(MOD + 1);

  logic [PW-1:0] phase;
  logic          active;
  logic [PW:0]   sum;
  logic [PW-1:0] phase_nx;
  logic [PW-1:0] fold;
  int            lvl;
  int            lvl_c;

  assign sum      = {1'b0, phase} + (tx_bit ? (PW+1)'(INC_MARK) : (PW+1)'(INC_SPACE));
  assign phase_nx = (sum >= (PW+1)'(MOD)) ? PW'(sum - (PW+1)'(MOD)) : PW'(sum);
  assign fold     = (phase < PW'(HALF)) ? phase : PW'(MOD) - phase;

  always_comb begin
    lvl   = int'(fold) - QTR;
    lvl_c = lvl;
    if (lvl > CLIP)  lvl_c = CLIP;
    if (lvl < -CLIP) lvl_c = -CLIP;
  end

  always_ff @(posedge clk) begin
    if (rst || rts_n) begin
      phase  <= PW'(QTR);
      active <= 1'b0;
    end else begin
      active <= 1'b1;
      if (active) phase <= phase_nx;
    end
  end

  assign dac_code   = active ? CODE_W'(MID + lvl_c) : CODE_W'(MID);
  assign dac_valid  = active;
  assign rx_disable = active;

  assert_phase_range_R1: assert property (@(posedge clk) disable iff (rst)
    int'(phase) < MOD);

  assert_no_jump_R3: assert property (@(posedge clk) disable iff (rst)
    (dac_valid && $past(dac_valid)) |->
      ((int'(dac_code) - int'($past(dac_code)) <= MAX_STEP) &&
       (int'($past(dac_code)) - int'(dac_code) <= MAX_STEP)));

  assert_clip_bounds_R4: assert property (@(posedge clk) disable iff (rst)
    (int'(dac_code) <= MID + CLIP) && (int'(dac_code) >= MID - CLIP));

  assert_idle_mid_R5: assert property (@(posedge clk) disable iff (rst)
    rts_n |=> (int'(dac_code) == MID && !dac_valid));

  assert_start_mid_R6: assert property (@(posedge clk) disable iff (rst)
    (!rts_n && !dac_valid) |=> (dac_valid && int'(dac_code) == MID));

  assert_rx_off_R7: assert property (@(posedge clk) disable iff (rst)
    !rts_n |=> rx_disable);

endmodule

// File: tb/fsk_tone_shaper_tb.sv
module fsk_tone_shaper_tb;
  localparam int MID = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rts_n = 1'b1;
  logic        tx_bit = 1'b1;
  logic [11:0] dac_code;
  logic        dac_valid;
  logic        rx_disable;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  fsk_tone_shaper u_dut (
    .clk(clk), .rst(rst), .rts_n(rts_n), .tx_bit(tx_bit),
    .dac_code(dac_code), .dac_valid(dac_valid), .rx_disable(rx_disable)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  // {tx_bit, expected code after the edge that used that bit}  (R8, R6)
  localparam logic [12:0] VEC [10] = '{
    {1'b1, 12'd2072}, {1'b1, 12'd2096}, {1'b0, 12'd2140}, {1'b0, 12'd2184},
    {1'b1, 12'd2208}, {1'b0, 12'd2252}, {1'b1, 12'd2276}, {1'b0, 12'd2320},
    {1'b0, 12'd2364}, {1'b1, 12'd2388}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic run_tone(input logic b, input int per, input string tag);
    int last_x, ivl, hi, lo, top, big, prev, cur;
    last_x = -1; ivl = -1; hi = 0; lo = 4096; top = 0; big = 0;
    tx_bit = b;
    prev = int'(dac_code);
    for (int i = 0; i < 6 * per; i++) begin
      tick();
      cur = int'(dac_code);
      if (prev < MID && cur >= MID) begin
        if (last_x >= 0) ivl = i - last_x;
        last_x = i;
      end
      if (cur > hi) hi = cur;
      if (cur < lo) lo = cur;
      if (cur == 3203 && prev == 3203) top++;
      if (cur - prev > big) big = cur - prev;
      if (prev - cur > big) big = prev - cur;
      prev = cur;
    end
    chk(ivl == per, tag, ivl, per);
    chk(hi == 3203, "R4 peak", hi, 3203);
    chk(lo == 893, "R4 trough", lo, 893);
    chk(top >= 6, "R4 plateau", top, 6);
    chk(big <= 44, "R3 step", big, 44);
  endtask

  initial begin
    int big, prev, cur;
    @(negedge clk);
    tick();
    chk(dac_code == 12'd2048 && !dac_valid && !rx_disable, "R9 reset state", int'(dac_code), MID);
    rst = 1'b0;
    tick();
    chk(dac_code == 12'd2048 && !dac_valid, "R5 idle", int'(dac_code), MID);
    chk(!rx_disable, "R7 idle rx", int'(rx_disable), 0);

    rts_n = 1'b0;
    tick();
    chk(dac_valid && dac_code == 12'd2048, "R6 first sample", int'(dac_code), MID);
    chk(rx_disable, "R7 tx rx", int'(rx_disable), 1);

    foreach (VEC[k]) begin
      tx_bit = VEC[k][12];
      tick();
      chk(dac_code == VEC[k][11:0], "R8 vector", int'(dac_code), int'(VEC[k][11:0]));
    end

    run_tone(1'b1, 385, "R1 mark period");
    run_tone(1'b0, 210, "R2 space period");

    big = 0;
    prev = int'(dac_code);
    for (int n = 0; n < 12; n++) begin
      tx_bit = n[0];
      for (int j = 0; j < 384; j++) begin
        tick();
        cur = int'(dac_code);
        if (cur - prev > big) big = cur - prev;
        if (prev - cur > big) big = prev - cur;
        prev = cur;
      end
    end
    chk(big <= 44, "R3 switching", big, 44);

    rts_n = 1'b1;
    tick();
    chk(dac_code == 12'd2048 && !dac_valid, "R5 gate off", int'(dac_code), MID);
    chk(!rx_disable, "R7 gate off rx", int'(rx_disable), 0);
    tick();
    chk(dac_code == 12'd2048, "R5 hold", int'(dac_code), MID);

    rts_n = 1'b0;
    tx_bit = 1'b0;
    tick();
    chk(dac_code == 12'd2048 && dac_valid, "R6 restart", int'(dac_code), MID);
    tick();
    chk(dac_code == 12'd2092, "R6 space slope", int'(dac_code), 2092);

    for (int j = 0; j < 30; j++) tick();
    rst = 1'b1;
    tick();
    chk(dac_code == 12'd2048 && !dac_valid && !rx_disable, "R9 mid reset", int'(dac_code), MID);
    rst = 1'b0;
    tick();
    chk(dac_valid && dac_code == 12'd2048, "R9 resume", int'(dac_code), MID);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule